// File: doc/BRIEF.md
# Glitch-Free Synchronous Clock Stop Gate

This block gates a group of clock outputs derived from one source clock. An asynchronous, active-low stop request is brought into the source clock domain through a short flop chain. The synchronized request then decides whether the group runs. A per-output enable mask can silence individual outputs at any time. One extra output is a copy of the source clock that neither the stop request nor the mask affects. It is meant for logic that must keep counting while the rest of the group is parked.

Each gated output is the source clock ANDed with an enable flop that loads on the falling edge. The enable can therefore only change while the clock is low. A stopped output always ends after a complete high phase and rests low. A restarted output always begins with a complete high phase.

After a restart the group is kept running for a minimum number of pulses, even if the stop request returns sooner. This gives each run a guaranteed minimum length.

Top module: `clkStopGroup`

## Requirements
- R1: While `rstN` is low every gated output is low and `freeClk` still toggles. After release, with `stopReqN` high and `enMask` all ones, every gated output pulses on each rising edge. The first pulse comes at the first rising edge after the first falling edge that follows release.
- R2: `stopReqN` passes through `SYNC_STAGES` flops clocked on the rising edge of `srcClk` before it is used. A low level sampled at exactly one rising edge removes exactly one pulse from the running group.
- R3: If `stopReqN` goes low before rising edge k and the minimum run is already complete, the enabled outputs pulse on edges k through k+`SYNC_STAGES`-1 and not after.
- R4: If `stopReqN` goes high before rising edge k while the group is stopped, the first pulse appears at edge k+`SYNC_STAGES` and pulses follow on every edge after it.
- R5: While stopped, every gated output is held low. The falling edge that follows the control dropping its run strobe clears all gate enables.
- R6: After a restart, at least `MIN_RUN` pulses are delivered before a stop takes effect. Suppose the restart request comes before edge 0 and the stop request comes before edge D. The group then delivers max(D, `MIN_RUN`) pulses in total.
- R7: `enMask[i]` = 1 enables `gatedClk[i]`, and 0 holds it low. The mask is sampled on the falling edge, so a change made during a high phase applies from the next pulse on.
- R8: `freeClk` follows `srcClk` at all times. It is unaffected by reset, the stop request and the mask.
- R9: Every high pulse on a gated output lasts exactly one half-period of `srcClk`. Gate enables change only while `srcClk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source clock for the whole group |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReqN | input | 1 | Asynchronous stop request, low stops the group |
| enMask | input | NUM_OUT | Per-output enable, 1 = running, 0 = held low |
| gatedClk | output | NUM_OUT | Gated clock outputs |
| freeClk | output | 1 | Ungated copy of the source clock |

## Verification
The bench builds the block with `NUM_OUT` = 3, `SYNC_STAGES` = 2 and `MIN_RUN` = 6. With this small group, all eight enable masks can be swept at full pulse-count precision. The restart-to-stop distance is swept from 1 to 10 edges, which covers runs both shorter and longer than the enforced minimum. A two-stage chain keeps the on and off latencies short enough to count edge by edge, and a one-edge request exposes the single missing pulse.

// File: rtl/clkStopPkg.sv
`timescale 1ns/1ps
package clkStopPkg;

  // Strobes from the control to the gating datapath.
  typedef struct packed {
    logic run;  // group may pulse from the next falling-edge load onward
  } gateStrobe_t;

endpackage

// File: rtl/clkStopSync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer. Resets to the "run" level so that the group
// comes out of reset running.
module clkStopSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '1;
    end else begin
      chain[0] <= asyncIn;
      for (int k = 1; k < STAGES; k++) begin
        chain[k] <= chain[k-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/clkStopCtrl.sv
`timescale 1ns/1ps
// Run control: follows the synchronized request, but holds the group
// running until MIN_RUN pulses have been delivered since the last restart.
module clkStopCtrl
  import clkStopPkg::*;
#(
  parameter int MIN_RUN = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqRun,
  output gateStrobe_t strobe
);

  localparam int CNT_W = (MIN_RUN > 2) ? $clog2(MIN_RUN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_RUN - 1);

  logic             runState;
  logic [CNT_W-1:0] runCnt;
  logic             minHold;
  logic             runNext;

  // runCnt + 1 equals the pulses already delivered in the current run.
  always_comb begin
    minHold = runState && (runCnt < LAST);
    runNext = reqRun || minHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runState <= 1'b1;
      runCnt   <= LAST;
    end else begin
      runState <= runNext;
      if (!runState) begin
        runCnt <= '0;
      end else if (runCnt != LAST) begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe     = '0;
    strobe.run = runNext;
  end

endmodule

// File: rtl/clkStopGate.sv
`timescale 1ns/1ps
// Gating datapath: one falling-edge enable flop and one AND per output.
module clkStopGate
  import clkStopPkg::*;
#(
  parameter int NUM_OUT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateStrobe_t        strobe,
  input  logic [NUM_OUT-1:0] enMask,
  output logic [NUM_OUT-1:0] gateEn,
  output logic [NUM_OUT-1:0] gatedClk,
  output logic               freeClk
);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic enQ;

    // Loads only on the falling edge, so it can change only while clk is low.
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ <= 1'b0;
      end else begin
        enQ <= strobe.run & enMask[g];
      end
    end

    assign gateEn[g]   = enQ;
    assign gatedClk[g] = clk & enQ;
  end

  assign freeClk = clk;

endmodule

// File: rtl/clkStopGroup.sv
`timescale 1ns/1ps
module clkStopGroup
  import clkStopPkg::*;
#(
  parameter int NUM_OUT     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 100
) (
  input  logic               srcClk,
  input  logic               rstN,
  input  logic               stopReqN,
  input  logic [NUM_OUT-1:0] enMask,
  output logic [NUM_OUT-1:0] gatedClk,
  output logic               freeClk
);

  logic               reqRunSync;
  gateStrobe_t        ctrlStrobe;
  logic [NUM_OUT-1:0] gateEnVec;

  clkStopSync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (srcClk),
    .rstN   (rstN),
    .asyncIn(stopReqN),
    .syncOut(reqRunSync)
  );

  clkStopCtrl #(
    .MIN_RUN(MIN_RUN)
  ) u_ctrl (
    .clk   (srcClk),
    .rstN  (rstN),
    .reqRun(reqRunSync),
    .strobe(ctrlStrobe)
  );

  clkStopGate #(
    .NUM_OUT(NUM_OUT)
  ) u_gate (
    .clk     (srcClk),
    .rstN    (rstN),
    .strobe  (ctrlStrobe),
    .enMask  (enMask),
    .gateEn  (gateEnVec),
    .gatedClk(gatedClk),
    .freeClk (freeClk)
  );

endmodule

// File: rtl/clkStopGroupChk.sv
`timescale 1ns/1ps
module clkStopGroupChk #(
  parameter int NUM_OUT = 6,
  parameter int MIN_RUN = 100
) (
  input logic               srcClk,
  input logic               rstN,
  input logic [NUM_OUT-1:0] enMask,
  input logic [NUM_OUT-1:0] gatedClk,
  input logic               runEn,
  input logic [NUM_OUT-1:0] gateEn
);

  localparam int LEN_W = $clog2(MIN_RUN + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MIN_RUN);

  // Length of the current run, counted in rising edges with run high.
  logic [LEN_W-1:0] runLen;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      runLen <= LEN_MAX;
    end else if (runEn) begin
      if (runLen != LEN_MAX) runLen <= runLen + 1'b1;
    end else begin
      runLen <= '0;
    end
  end

  // R9: gate enables move only in the low phase.
  always @(gateEn) begin
    if (rstN) begin
      assert_enable_moves_low_R9: assert (!srcClk);
    end
  end

  // R5: a dropped run strobe clears every enable at the next falling edge.
  assert_stop_clears_gates_R5: assert property (
    @(negedge srcClk) disable iff (!rstN) !runEn |=> (gateEn == '0));

  // R6: a run never ends before MIN_RUN pulses.
  assert_min_run_R6: assert property (
    @(posedge srcClk) disable iff (!rstN)
      (!runEn && runLen != '0) |-> (runLen >= LEN_MAX));

  // R7: a cleared mask bit suppresses the following pulse of its output.
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_mask
    assert_mask_holds_low_R7: assert property (
      @(negedge srcClk) disable iff (!rstN) !enMask[g] |=> !gatedClk[g]);
  end

endmodule

bind clkStopGroup clkStopGroupChk #(
  .NUM_OUT(NUM_OUT),
  .MIN_RUN(MIN_RUN)
) i_chk (
  .srcClk  (srcClk),
  .rstN    (rstN),
  .enMask  (enMask),
  .gatedClk(gatedClk),
  .runEn   (ctrlStrobe.run),
  .gateEn  (gateEnVec)
);

// File: tb/test_clkStopGroup.sv
`timescale 1ns/1ps
module test_clkStopGroup;

  localparam int NOUT    = 3;
  localparam int STAGES  = 2;
  localparam int MINRUN  = 6;
  localparam realtime HALF = 4.0;

  logic            clk = 1'b0;
  logic            rstN;
  logic            stopReqN;
  logic [NOUT-1:0] enMask;
  logic [NOUT-1:0] gatedClk;
  logic            freeClk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int pulseCnt [NOUT];
  int baseCnt  [NOUT];
  int freeCnt = 0;
  int freeBase = 0;
  int runts = 0;
  realtime riseT [NOUT];
  logic [NOUT-1:0] prevG = '0;

  clkStopGroup #(
    .NUM_OUT(NOUT),
    .SYNC_STAGES(STAGES),
    .MIN_RUN(MINRUN)
  ) i_clkStopGroup (
    .srcClk  (clk),
    .rstN    (rstN),
    .stopReqN(stopReqN),
    .enMask  (enMask),
    .gatedClk(gatedClk),
    .freeClk (freeClk)
  );

  always #4 clk = ~clk;

  initial begin
    for (int i = 0; i < NOUT; i++) begin
      pulseCnt[i] = 0;
      riseT[i] = 0.0;
    end
  end

  // Pulse counter and width monitor (R9).
  always @(gatedClk) begin
    for (int i = 0; i < NOUT; i++) begin
      if (gatedClk[i] === 1'b1 && prevG[i] !== 1'b1) begin
        riseT[i] = $realtime;
        pulseCnt[i] = pulseCnt[i] + 1;
      end else if (gatedClk[i] !== 1'b1 && prevG[i] === 1'b1) begin
        if ($realtime - riseT[i] != HALF) runts = runts + 1;
      end
    end
    prevG = gatedClk;
  end

  always @(posedge freeClk) freeCnt = freeCnt + 1;

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < NOUT; i++) baseCnt[i] = pulseCnt[i];
    freeBase = freeCnt;
  endtask

  // Advance n rising edges, leaving time at edge + 2 ns (inside high phase).
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic checkAll(input string tag, input int exp);
    for (int i = 0; i < NOUT; i++) begin
      checkEq($sformatf("%s out%0d", tag, i), pulseCnt[i] - baseCnt[i], exp);
    end
  endtask

  initial begin
    rstN = 1'b0;
    stopReqN = 1'b1;
    enMask = '1;
    edges(3);

    // R1: reset state
    checkEq("R1 gated low in reset", int'(gatedClk), 0);
    checkEq("R1 freeClk high phase in reset", int'(freeClk), 1);
    snap();
    edges(4);
    checkEq("R8 free edges during reset", freeCnt - freeBase, 4);
    checkAll("R1 no pulses in reset", 0);

    rstN = 1'b1;
    snap();
    edges(8);
    checkAll("R1 running after reset", 8);
    edges(10);

    // R3 off latency, R5 held low, R8 free clock
    stopReqN = 1'b0;
    snap();
    edges(STAGES);
    checkAll("R3 pulses after stop request", STAGES);
    edges(10);
    checkAll("R5 no pulses while stopped", STAGES);
    checkEq("R5 outputs low while stopped", int'(gatedClk), 0);
    checkEq("R8 free runs while stopped", freeCnt - freeBase, STAGES + 10);

    // R4 on latency
    stopReqN = 1'b1;
    snap();
    edges(STAGES);
    checkAll("R4 no pulse before latency", 0);
    edges(1);
    checkAll("R4 first pulse at latency", 1);
    edges(5);
    checkAll("R4 every edge after restart", 6);
    edges(20);

    // R2 one-edge request removes one pulse
    stopReqN = 1'b0;
    snap();
    edges(1);
    stopReqN = 1'b1;
    edges(19);
    checkAll("R2 one-edge stop", 19);
    checkEq("R8 free during short stop", freeCnt - freeBase, 20);
    edges(20);

    // R6 restart-to-stop distance sweep
    stopReqN = 1'b0;
    edges(20);
    for (int d = 1; d <= 10; d++) begin
      stopReqN = 1'b1;
      snap();
      edges(d);
      stopReqN = 1'b0;
      edges(30);
      checkAll($sformatf("R6 run length d=%0d", d), (d > MINRUN) ? d : MINRUN);
    end

    // R7 exhaustive mask sweep while running
    stopReqN = 1'b1;
    edges(20);
    for (int m = 0; m < (1 << NOUT); m++) begin
      enMask = NOUT'(m);
      snap();
      edges(8);
      for (int i = 0; i < NOUT; i++) begin
        checkEq($sformatf("R7 mask=%0d out%0d", m, i), pulseCnt[i] - baseCnt[i],
                ((m >> i) & 1) ? 8 : 0);
      end
      checkEq($sformatf("R8 free with mask=%0d", m), freeCnt - freeBase, 8);
    end

    // R9 pulse widths over the whole run
    checkEq("R9 runt pulses", runts, 0);
    checkEq("R9 pulses observed", (pulseCnt[0] > 50) ? 1 : 0, 1);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule